// File: doc/BRIEF.md
# DDR2 Controller Initialization Register Block

This block is the software-visible register front end of a DDR2 memory controller. It sits on a simple 32-bit register bus with separate read and write strobes, and it holds four kinds of state. There is a 16-bit configuration word and a status word with a start-initialization command bit. There is a bank of plain 32-bit words for timing and ECC settings. There is also a fixed revision code. DRAM command sequencing, refresh and PHY timing are not part of this block.

Software starts memory bring-up by writing the status word with the mode-register-set command bit (bit 0) set. The block answers in the same clock edge. The command bit clears itself, a sticky init-done flag appears at status bit 8, and the registered `mem_en` output rises. `mem_en` tells the system address decode that DRAM may be mapped, and it stays high until reset. A boot-retention input lets a reset keep `mem_en` asserted, so a warm restart does not unmap memory that is already running.

Reads are combinational from the current register state. An access to an address outside the legal set gives a one-cycle error flag and reads as zero. Illegal addresses are offsets above 0x50 in the 4 KiB window and addresses that are not word aligned.

Top module: `ddr_init_regs`

## Requirements
- R1: A synchronous, active-high reset with `boot_keep` low makes every readable register read zero (offset 0x50 excepted) and drops `mem_en` to 0 at the next edge.
- R2: Offset 0x00 (configuration) keeps bits [15:0] of a write; bits [31:16] always read 0.
- R3: A write to offset 0x04 (status) stores only bits [5:0] of the data. Bit 8 (init-done) keeps its current value and cannot be cleared by a write. All other bits read 0.
- R4: While `mem_en` is low, a status write with bit 0 set stores bits [5:1] as written and bit 0 as 0. At that same edge it sets bit 8 and raises `mem_en`.
- R5: While `mem_en` is high, a status write stores bit 0 as written. It does not change bit 8 or `mem_en`.
- R6: Offsets 0x08 to 0x4C are eighteen independent 32-bit read/write words, and all 32 bits are kept.
- R7: A read at offset 0x50 returns 0x00000100, and a write there changes nothing.
- R8: A reset with `boot_keep` high keeps `mem_en` high if it was high. Status bit 8 reads 1 whenever `mem_en` is high, even after reset has cleared the stored registers.
- R9: An access to an offset above 0x50 or to a non-aligned address reads 0 and drives `err` high during that strobe cycle only. A write there changes no register. Legal accesses keep `err` low.
- R10: Once high, `mem_en` stays high until a reset with `boot_keep` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_keep | input | 1 | When high, reset keeps `mem_en` |
| addr | input | 12 | Byte address inside the 4 KiB register window |
| wr_en | input | 1 | Write strobe, acts at the rising edge |
| rd_en | input | 1 | Read strobe, qualifies the error flag |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |
| err | output | 1 | Illegal-access flag, high during the strobe cycle |
| mem_en | output | 1 | Registered DRAM-enable level |

## Verification
The hardest state to reach is the one where `mem_en` is high but the init-done flag and all other registers have been cleared. This state only exists after a reset taken with `boot_keep` high. The bench first completes a mode-register-set command, then resets with `boot_keep` high. It then checks three things: status bit 8 still reads 1, everything else reads 0, and a new status write with bit 0 set is stored as data rather than starting the enable sequence again. A later reset with `boot_keep` low must then drop the enable, and the command must work again from that clean state.

// File: rtl/ddr_init_regs.sv
module ddr_init_regs #(
  parameter int          ADDR_W    = 12,
  parameter int          NUM_STORE = 18,
  parameter logic [31:0] REV_CODE  = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_keep,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              err,
  output logic              mem_en
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int SW    = (NUM_STORE > 1) ? $clog2(NUM_STORE) : 1;
  localparam logic [IDX_W-1:0] CFG_I   = IDX_W'(0);
  localparam logic [IDX_W-1:0] STS_I   = IDX_W'(1);
  localparam logic [IDX_W-1:0] FIRST_I = IDX_W'(2);
  localparam logic [IDX_W-1:0] LAST_I  = IDX_W'(2 + NUM_STORE - 1);
  localparam logic [IDX_W-1:0] REV_I   = IDX_W'(2 + NUM_STORE);

  logic [IDX_W-1:0] idx;
  logic             legal, in_store, wr_ok;
  logic [SW-1:0]    sidx;
  logic [15:0]      cfg_q;
  logic [5:0]       sts_q;
  logic             done_q;
  logic [31:0]      store_q [NUM_STORE];

  assign idx      = addr[ADDR_W-1:2];
  assign legal    = (addr[1:0] == 2'b00) && (idx <= REV_I);
  assign in_store = (idx >= FIRST_I) && (idx <= LAST_I);
  assign sidx     = SW'(idx - FIRST_I);
  assign wr_ok    = wr_en && legal && !rst;
  assign err      = (wr_en || rd_en) && !legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      sts_q  <= '0;
      done_q <= 1'b0;
      mem_en <= mem_en && boot_keep;
    end else if (wr_ok && idx == CFG_I) begin
      cfg_q <= wdata[15:0];
    end else if (wr_ok && idx == STS_I) begin
      if (!mem_en && wdata[0]) begin
        sts_q  <= {wdata[5:1], 1'b0};
        done_q <= 1'b1;
        mem_en <= 1'b1;
      end else begin
        sts_q <= wdata[5:0];
      end
    end
  end

  for (genvar g = 0; g < NUM_STORE; g++) begin : g_store
    always_ff @(posedge clk) begin
      if (rst)
        store_q[g] <= '0;
      else if (wr_ok && in_store && sidx == SW'(g))
        store_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (legal) begin
      if (idx == CFG_I)
        rdata = {16'h0, cfg_q};
      else if (idx == STS_I)
        rdata = {23'h0, done_q | mem_en, 2'b00, sts_q};
      else if (in_store)
        rdata = store_q[sidx];
      else if (idx == REV_I)
        rdata = REV_CODE;
    end
  end
endmodule

module ddr_init_regs_chk #(
  parameter int          ADDR_W    = 12,
  parameter int          NUM_STORE = 18,
  parameter logic [31:0] REV_CODE  = 32'h0000_0100
) (
  input logic              clk,
  input logic              rst,
  input logic              boot_keep,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              err,
  input logic              mem_en
);
  localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] REV_A = ADDR_W'(4 * (2 + NUM_STORE));

  a_r4_mrs_enables: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == STS_A && wdata[0] && !mem_en) |=> mem_en);

  a_r10_enable_holds: assert property (@(posedge clk) disable iff (rst)
    mem_en |=> mem_en);

  a_r1_reset_drops: assert property (@(posedge clk)
    (rst && !boot_keep) |=> !mem_en);

  a_r8_done_visible: assert property (@(posedge clk) disable iff (rst)
    (mem_en && addr == STS_A) |-> rdata[8]);

  a_r9_err_reads_zero: assert property (@(posedge clk) disable iff (rst)
    err |-> (rdata == 32'h0));

  a_r7_revision: assert property (@(posedge clk) disable iff (rst)
    (addr == REV_A) |-> (rdata == REV_CODE && !err));
endmodule

bind ddr_init_regs ddr_init_regs_chk #(
  .ADDR_W(ADDR_W), .NUM_STORE(NUM_STORE), .REV_CODE(REV_CODE)
) u_chk (.*);

// File: tb/tb_ddr_init_regs.sv
`timescale 1ns/1ps
module tb_ddr_init_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        boot_keep = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic        mem_en;

  int checks = 0;
  int fails  = 0;
  logic [31:0] rv;
  logic        re;

  always #4 clk = ~clk;

  ddr_init_regs dut (
    .clk(clk), .rst(rst), .boot_keep(boot_keep), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
    .rdata(rdata), .err(err), .mem_en(mem_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic keep);
    @(negedge clk);
    boot_keep = keep; rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0; boot_keep = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; rd_en = 1'b0;
    #2 re = err;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk);
    addr = a; rd_en = 1'b1; wr_en = 1'b0;
    #2 rv = rdata; re = err;
    @(posedge clk);
    #1 rd_en = 1'b0;
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    rd(12'h000); check("R1 cfg", rv, 0);
    rd(12'h004); check("R1 status", rv, 0);
    rd(12'h030); check("R1 store", rv, 0);
    check("R1 mem_en", {31'h0, mem_en}, 0);
  endtask

  task automatic t_cfg;
    wr(12'h000, 32'hDEAD_BEEF);
    rd(12'h000); check("R2 cfg low half", rv, 32'h0000_BEEF);
  endtask

  task automatic t_store;
    wr(12'h008, 32'h1234_5678);
    wr(12'h04C, 32'hA5A5_5A5A);
    wr(12'h020, 32'hFFFF_0001);
    rd(12'h008); check("R6 first word", rv, 32'h1234_5678);
    rd(12'h04C); check("R6 last word", rv, 32'hA5A5_5A5A);
    rd(12'h020); check("R6 middle word", rv, 32'hFFFF_0001);
    rd(12'h024); check("R6 neighbour untouched", rv, 0);
  endtask

  task automatic t_rev;
    rd(12'h050); check("R7 revision", rv, 32'h0000_0100);
    wr(12'h050, 32'hFFFF_FFFF);
    rd(12'h050); check("R7 revision after write", rv, 32'h0000_0100);
  endtask

  task automatic t_bad;
    rd(12'h054); check("R9 rd above range data", rv, 0); check("R9 rd above range err", {31'h0, re}, 1);
    rd(12'hFFC); check("R9 rd top of window err", {31'h0, re}, 1);
    rd(12'h002); check("R9 misaligned data", rv, 0); check("R9 misaligned err", {31'h0, re}, 1);
    wr(12'h00A, 32'hCAFE_CAFE); check("R9 wr misaligned err", {31'h0, re}, 1);
    rd(12'h008); check("R9 misaligned write ignored", rv, 32'h1234_5678); check("R9 legal no err", {31'h0, re}, 0);
    wr(12'h001, 32'h0000_0001);
    rd(12'h000); check("R9 cfg unchanged", rv, 32'h0000_BEEF);
    check("R9 no enable from bad write", {31'h0, mem_en}, 0);
    @(negedge clk); #2 check("R9 err idle", {31'h0, err}, 0);
  endtask

  task automatic t_status_plain;
    wr(12'h004, 32'hFFFF_FF3E);
    rd(12'h004); check("R3 low six bits only", rv, 32'h0000_003E);
    check("R3 no enable", {31'h0, mem_en}, 0);
  endtask

  task automatic t_mrs;
    wr(12'h004, 32'h0000_0023);
    #1 check("R4 mem_en at edge", {31'h0, mem_en}, 1);
    rd(12'h004); check("R4 bit0 cleared bit8 set", rv, 32'h0000_0122);
  endtask

  task automatic t_after;
    wr(12'h004, 32'h0000_003F);
    rd(12'h004); check("R5 bit0 stored", rv, 32'h0000_013F);
    wr(12'h004, 32'h0000_0000);
    rd(12'h004); check("R3 bit8 not clearable", rv, 32'h0000_0100);
    wr(12'h000, 32'h0);
    check("R10 mem_en holds", {31'h0, mem_en}, 1);
  endtask

  task automatic t_bootkeep;
    do_reset(1'b1);
    check("R8 mem_en retained", {31'h0, mem_en}, 1);
    rd(12'h004); check("R8 bit8 visible", rv, 32'h0000_0100);
    rd(12'h008); check("R8 store cleared", rv, 0);
    rd(12'h000); check("R8 cfg cleared", rv, 0);
    wr(12'h004, 32'h0000_0001);
    rd(12'h004); check("R5 no retrigger after warm reset", rv, 32'h0000_0101);
  endtask

  task automatic t_drop;
    do_reset(1'b0);
    check("R1 mem_en dropped", {31'h0, mem_en}, 0);
    rd(12'h004); check("R1 status cleared", rv, 0);
    wr(12'h004, 32'h0000_0001);
    rd(12'h004); check("R4 second enable", rv, 32'h0000_0100);
    check("R4 mem_en again", {31'h0, mem_en}, 1);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset;
    t_cfg;
    t_store;
    t_rev;
    t_bad;
    t_status_plain;
    t_mrs;
    t_after;
    t_bootkeep;
    t_drop;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule